// File: doc/BRIEF.md
# Two-wire serial target protocol engine

This block is the protocol core of a two-wire serial (I2C) target. A fast system clock samples the SCL and SDA lines through a short synchronizer. The block finds bus conditions from the sampled lines: START, repeated START and STOP. It shifts in an address byte and write bytes, and it acknowledges each byte it accepts by pulling SDA low. In read transfers it shifts out data and watches the controller's acknowledge bit. SDA is open-drain: the block only asserts `sda_oe_o`, which pulls the line low, and never drives it high.

On the register side there are two valid/ready streams. Writes leave as address/data beats. A write beat stays valid, with its address and data stable, until `wr_ready_i` is high on a clock edge. The consumer must accept it before the next data byte completes; otherwise the newer beat replaces it. A read request gives an address on `rd_addr_o` while `rd_valid_o` is high. The responder presents `rd_data_i` and raises `rd_ready_i`, and the byte is taken on that edge. The responder must answer before the SCL falling edge on which the first bit of that byte is driven. There is no clock stretching, so the bus cannot wait for a slow responder. An internal register pointer selects the address used on both streams.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset `sda_oe_o`, `wr_valid_o` and `rd_valid_o` are all low.
- R2: After a START, the first 8 bits sampled on SCL rising edges (MSB first) form the address byte. Bits 7..1 are the device address and bit 0 selects the direction (1 = read). When bits 7..1 equal `DEV_ADDR`, SDA is held low for the whole 9th SCL high pulse.
- R3: On an address mismatch there is no acknowledge. SDA stays released and neither stream is used until the next START or STOP.
- R4: In a write transfer every data byte is acknowledged. The first data byte loads the register pointer and produces no write beat. Each later byte produces one write beat at the pointer, and the pointer then increments.
- R5: In a read transfer, bytes are fetched from the pointer, which increments after each fetched byte. Bits go out MSB first, with SDA changed only after SCL falls. A low 9th bit from the controller (ACK) sends the next byte. A high 9th bit (NACK) makes the block release SDA and stay silent until START or STOP.
- R6: A STOP (SDA rising while SCL is high) at any bit position returns the block to idle with SDA released. A partly received byte is dropped and gives no write beat.
- R7: A STOP that falls in the same SCL high pulse as the START is ignored. The address phase that the START began continues.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values.
- R9: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_valid_o` and `rd_addr_o` hold their values. The byte returned on the handshake edge is the one shifted out.
- R10: The block starts pulling SDA low only while the synchronized SCL is low.
- R11: A START during an active transfer (repeated START) begins a new address phase without passing through idle. The pointer value is kept across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | PTR_W | Write register address |
| wr_data_o | output | 8 | Write data |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read data presented on rd_data_i |
| rd_addr_o | output | PTR_W | Read register address |
| rd_data_i | input | 8 | Read data, taken on the handshake edge |

## Verification
Two events can land in the same SCL high pulse: a START and a STOP. The START sets a hold flag that lasts until SCL falls. The bench pulls SDA low and then back high within a single high pulse, then clocks an address byte without a new START. If the block acknowledges that byte, the STOP was ignored. The second race is a read fetch against the SCL fall that must drive the next bit: the bench's register file answers only after several cycles, and the bytes that arrive on the bus are compared against the model's contents.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W  = 8;
  localparam int DEVA_W  = 7;
  localparam int CNT_W   = $clog2(BYTE_W + 2);

  localparam logic [CNT_W-1:0] CNT_LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK_DONE = CNT_W'(BYTE_W + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_MUTE
  } phase_e;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond_det.sv
module i2c_tgt_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic stop_raw,
  output logic cond_stop,
  output logic start_hold
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign cond_start = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_raw   = scl_s & scl_q & ~sda_q & sda_s;

  // A START arms the hold; the SCL fall that ends its high pulse disarms it.
  always_ff @(posedge clk) begin
    if (!rst_n)          start_hold <= 1'b0;
    else if (cond_start) start_hold <= 1'b1;
    else if (scl_fall)   start_hold <= 1'b0;
  end

  assign cond_stop = stop_raw & ~start_hold;
endmodule

// File: rtl/i2c_tgt_proto.sv
module i2c_tgt_proto
  import i2c_tgt_pkg::*;
#(
  parameter logic [DEVA_W-1:0] DEV_ADDR = 7'h4A
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   scl_rise,
  input  logic   scl_fall,
  input  logic   cond_start,
  input  logic   cond_stop,
  input  logic   sda_s,
  input  logic   tx_load,
  input  byte_t  tx_byte,
  output logic   sda_oe,
  output logic   ptr_set,
  output logic   wr_push,
  output logic   rd_fetch,
  output byte_t  rx_byte,
  output phase_e phase
);
  logic [CNT_W-1:0] cnt;
  byte_t shreg, txreg, next_byte;
  logic  ack_en, rw, first_wr, ctl_ack;

  assign next_byte = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txreg    <= '0;
      rx_byte  <= '0;
      ack_en   <= 1'b0;
      rw       <= 1'b0;
      first_wr <= 1'b0;
      ctl_ack  <= 1'b0;
      sda_oe   <= 1'b0;
      ptr_set  <= 1'b0;
      wr_push  <= 1'b0;
      rd_fetch <= 1'b0;
    end else begin
      ptr_set  <= 1'b0;
      wr_push  <= 1'b0;
      rd_fetch <= 1'b0;
      if (tx_load) txreg <= tx_byte;

      if (cond_stop) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        ack_en <= 1'b0;
        sda_oe <= 1'b0;
      end else if (cond_start) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        ack_en <= 1'b0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (phase)
          PH_ADDR, PH_WRITE: begin
            if (cnt < CNT_ACK_SLOT) begin
              shreg <= next_byte;
              cnt   <= cnt + 1'b1;
              if (cnt == CNT_LAST_BIT) begin
                if (phase == PH_ADDR) begin
                  if (next_byte[BYTE_W-1:1] == DEV_ADDR) begin
                    ack_en   <= 1'b1;
                    rw       <= next_byte[0];
                    first_wr <= 1'b1;
                    rd_fetch <= next_byte[0];
                  end else begin
                    phase <= PH_MUTE;
                  end
                end else begin
                  ack_en  <= 1'b1;
                  rx_byte <= next_byte;
                  if (first_wr) begin
                    ptr_set  <= 1'b1;
                    first_wr <= 1'b0;
                  end else begin
                    wr_push <= 1'b1;
                  end
                end
              end
            end else if (cnt == CNT_ACK_SLOT) begin
              cnt <= CNT_ACK_DONE;
            end
          end
          PH_READ: begin
            if (cnt < CNT_ACK_SLOT) begin
              cnt <= cnt + 1'b1;
            end else if (cnt == CNT_ACK_SLOT) begin
              cnt      <= CNT_ACK_DONE;
              ctl_ack  <= ~sda_s;
              rd_fetch <= ~sda_s;
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (phase)
          PH_ADDR, PH_WRITE: begin
            if (cnt == CNT_ACK_SLOT) begin
              sda_oe <= ack_en;
            end else if (cnt == CNT_ACK_DONE) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              ack_en <= 1'b0;
              if (phase == PH_ADDR) begin
                if (rw) begin
                  phase  <= PH_READ;
                  sda_oe <= ~txreg[BYTE_W-1];
                  txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                end else begin
                  phase <= PH_WRITE;
                end
              end
            end
          end
          PH_READ: begin
            if (cnt != '0 && cnt < CNT_ACK_SLOT) begin
              sda_oe <= ~txreg[BYTE_W-1];
              txreg  <= {txreg[BYTE_W-2:0], 1'b0};
            end else if (cnt == CNT_ACK_SLOT) begin
              sda_oe <= 1'b0;
            end else if (cnt == CNT_ACK_DONE) begin
              cnt <= '0;
              if (ctl_ack) begin
                sda_oe <= ~txreg[BYTE_W-1];
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              end else begin
                phase  <= PH_MUTE;
                sda_oe <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_regport.sv
module i2c_tgt_regport
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_set,
  input  logic             wr_push,
  input  logic             rd_fetch,
  input  byte_t            byte_in,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [PTR_W-1:0] wr_addr,
  output byte_t            wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [PTR_W-1:0] rd_addr,
  input  byte_t            rd_data,
  output logic             tx_load,
  output byte_t            tx_byte
);
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      tx_load  <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_load <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (ptr_set) ptr <= PTR_W'(byte_in);
      if (wr_push) begin
        wr_valid <= 1'b1;
        wr_addr  <= ptr;
        wr_data  <= byte_in;
        ptr      <= ptr + 1'b1;
      end
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        tx_load  <= 1'b1;
        tx_byte  <= rd_data;
        ptr      <= ptr + 1'b1;
      end else if (rd_fetch) begin
        rd_valid <= 1'b1;
        rd_addr  <= ptr;
      end
    end
  end
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [DEVA_W-1:0] DEV_ADDR = 7'h4A,
  parameter int PTR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [PTR_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i
);
  logic   scl_s, sda_s;
  logic   scl_rise, scl_fall, cond_start, stop_raw, cond_stop, start_hold;
  logic   ptr_set, wr_push, rd_fetch, tx_load;
  byte_t  rx_byte, tx_byte;
  phase_e phase;

  i2c_tgt_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout ({scl_s, sda_s})
  );

  i2c_tgt_cond_det u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .cond_start(cond_start),
    .stop_raw  (stop_raw),
    .cond_stop (cond_stop),
    .start_hold(start_hold)
  );

  i2c_tgt_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .cond_start(cond_start),
    .cond_stop (cond_stop),
    .sda_s     (sda_s),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .sda_oe    (sda_oe_o),
    .ptr_set   (ptr_set),
    .wr_push   (wr_push),
    .rd_fetch  (rd_fetch),
    .rx_byte   (rx_byte),
    .phase     (phase)
  );

  i2c_tgt_regport #(.PTR_W(PTR_W)) u_regport (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr_set (ptr_set),
    .wr_push (wr_push),
    .rd_fetch(rd_fetch),
    .byte_in (rx_byte),
    .wr_valid(wr_valid_o),
    .wr_ready(wr_ready_i),
    .wr_addr (wr_addr_o),
    .wr_data (wr_data_o),
    .rd_valid(rd_valid_o),
    .rd_ready(rd_ready_i),
    .rd_addr (rd_addr_o),
    .rd_data (rd_data_i),
    .tx_load (tx_load),
    .tx_byte (tx_byte)
  );
endmodule

// File: rtl/i2c_target_engine_chk.sv
module i2c_target_engine_chk
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input phase_e           phase,
  input logic             stop_raw,
  input logic             start_hold,
  input logic             cond_stop,
  input logic             wr_push,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [PTR_W-1:0] wr_addr,
  input logic [7:0]       wr_data,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [PTR_W-1:0] rd_addr
);
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cond_stop |=> (phase == PH_IDLE && !sda_oe));

  p_same_pulse_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_raw && start_hold) |=> (phase != PH_IDLE));

  p_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_MUTE) |-> !sda_oe);

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !wr_push) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
endmodule

bind i2c_target_engine i2c_target_engine_chk #(.PTR_W(PTR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe_o),
  .phase     (phase),
  .stop_raw  (stop_raw),
  .start_hold(start_hold),
  .cond_stop (cond_stop),
  .wr_push   (wr_push),
  .wr_valid  (wr_valid_o),
  .wr_ready  (wr_ready_i),
  .wr_addr   (wr_addr_o),
  .wr_data   (wr_data_o),
  .rd_valid  (rd_valid_o),
  .rd_ready  (rd_ready_i),
  .rd_addr   (rd_addr_o)
);

// File: tb/test_i2c_target_engine.sv
`timescale 1ns/1ps
module test_i2c_target_engine;
  localparam int Q = 10;
  localparam int RD_LAT = 4;
  localparam logic [7:0] AW = 8'h94;
  localparam logic [7:0] AR = 8'h95;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_ctl = 1'b1;
  logic sda_bus;
  logic sda_oe, wr_valid, wr_rdy, rd_valid, rd_rdy;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] mem [256];
  int wr_cnt, rd_wait, rd_stab_err;
  logic [7:0] rd_addr_first;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_bus = sda_ctl & ~sda_oe;

  i2c_target_engine i_i2c_target_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_rdy), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_rdy), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  // Register file model: write consumer and slow read responder.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 3 + 1);
      wr_cnt <= 0;
    end else if (wr_valid && wr_rdy) begin
      mem[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  assign rd_rdy  = rd_valid && (rd_wait >= RD_LAT);
  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_wait <= 0; rd_addr_first <= '0; rd_stab_err <= 0;
    end else if (rd_valid && !rd_rdy) begin
      if (rd_wait == 0) rd_addr_first <= rd_addr;
      else if (rd_addr != rd_addr_first) rd_stab_err <= rd_stab_err + 1;
      rd_wait <= rd_wait + 1;
    end else begin
      rd_wait <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, output logic smid, output logic slate);
    sda_ctl = b; wn(Q);
    scl = 1'b1; wn(10); smid = sda_bus; wn(9); slate = sda_bus; wn(1);
    scl = 1'b0; wn(Q);
  endtask

  task automatic send_start();
    sda_ctl = 1'b1; wn(Q); scl = 1'b1; wn(Q); sda_ctl = 1'b0; wn(Q); scl = 1'b0; wn(Q);
  endtask

  task automatic send_stop();
    sda_ctl = 1'b0; wn(Q); scl = 1'b1; wn(Q); sda_ctl = 1'b1; wn(Q); wn(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic acked);
    logic m, l;
    for (int i = 7; i >= 0; i--) pulse(v[i], m, l);
    pulse(1'b1, m, l);
    acked = !m && !l;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v);
    logic m, l;
    for (int i = 7; i >= 0; i--) begin
      pulse(1'b1, m, l);
      v[i] = m;
    end
    pulse(!give_ack, m, l);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 wr_valid after reset", int'(wr_valid), 0);
    chk("R1 rd_valid after reset", int'(rd_valid), 0);
  endtask

  task automatic t_write();
    logic a; int base;
    base = wr_cnt;
    send_start();
    write_byte(AW, a); chk("R2 address ack", int'(a), 1);
    write_byte(8'h10, a); chk("R4 pointer byte ack", int'(a), 1);
    wn(5); chk("R4 pointer byte gives no write", wr_cnt - base, 0);
    write_byte(8'hA5, a); chk("R4 data ack", int'(a), 1);
    write_byte(8'h3C, a);
    send_stop(); wn(4);
    chk("R4 write count", wr_cnt - base, 2);
    chk("R4 mem[10]", int'(mem[8'h10]), 8'hA5);
    chk("R4 mem[11] after increment", int'(mem[8'h11]), 8'h3C);
    chk("R6 SDA released after stop", int'(sda_oe), 0);
  endtask

  task automatic t_read();
    logic a, m, l; logic [7:0] v;
    send_start();
    write_byte(AW, a);
    write_byte(8'h10, a);
    send_start();
    write_byte(AR, a); chk("R11 repeated start read address ack", int'(a), 1);
    read_byte(1'b1, v); chk("R5 read byte 0", int'(v), 8'hA5);
    read_byte(1'b0, v); chk("R5 read byte 1", int'(v), 8'h3C);
    pulse(1'b1, m, l); chk("R5 silent after NACK", int'(m && l), 1);
    send_stop();
    send_start();
    write_byte(AR, a);
    read_byte(1'b0, v); chk("R5 pointer incremented across transfers", int'(v), 8'h37);
    send_stop();
    chk("R9 read address stable while waiting", rd_stab_err, 0);
  endtask

  task automatic t_wrong_addr();
    logic a; int base;
    base = wr_cnt;
    send_start();
    write_byte(8'h44, a); chk("R3 no ack on mismatch", int'(a), 0);
    write_byte(8'h55, a); chk("R3 silent after mismatch", int'(a), 0);
    chk("R3 no read request", int'(rd_valid), 0);
    send_stop(); wn(4);
    chk("R3 no write beat", wr_cnt - base, 0);
  endtask

  task automatic t_mid_stop();
    logic a, m, l; int base;
    base = wr_cnt;
    send_start();
    write_byte(AW, a);
    write_byte(8'h20, a);
    write_byte(8'h77, a);
    pulse(1'b1, m, l); pulse(1'b0, m, l); pulse(1'b1, m, l); pulse(1'b1, m, l);
    send_stop(); wn(4);
    chk("R6 only full byte committed", wr_cnt - base, 1);
    chk("R6 mem[20]", int'(mem[8'h20]), 8'h77);
    chk("R6 partial byte dropped mem[21]", int'(mem[8'h21]), 8'h64);
    write_byte(AW, a); chk("R6 idle after mid-byte stop", int'(a), 0);
    send_stop();
  endtask

  task automatic t_same_pulse();
    logic a;
    sda_ctl = 1'b1; scl = 1'b1; wn(Q);
    sda_ctl = 1'b0; wn(Q);
    sda_ctl = 1'b1; wn(Q);
    scl = 1'b0; wn(Q);
    write_byte(AW, a); chk("R7 stop in start pulse ignored", int'(a), 1);
    write_byte(8'h30, a);
    write_byte(8'h99, a);
    send_stop(); wn(4);
    chk("R7 write after ignored stop", int'(mem[8'h30]), 8'h99);
  endtask

  task automatic t_backpressure();
    logic a;
    wr_rdy = 1'b0;
    send_start();
    write_byte(AW, a);
    write_byte(8'h40, a);
    write_byte(8'hC3, a);
    chk("R8 wr_valid raised", int'(wr_valid), 1);
    wn(40);
    chk("R8 wr_valid held", int'(wr_valid), 1);
    chk("R8 wr_addr held", int'(wr_addr), 8'h40);
    chk("R8 wr_data held", int'(wr_data), 8'hC3);
    wr_rdy = 1'b1; wn(4);
    chk("R8 beat accepted", int'(mem[8'h40]), 8'hC3);
    send_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wr_rdy = 1'b1;
    wn(6); rst_n = 1'b1; wn(4);
    t_reset();
    t_write();
    t_read();
    t_wrong_addr();
    t_mid_stop();
    t_same_pulse();
    t_backpressure();
    wn(10);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule